// File: doc/BRIEF.md
# Zeroizing Message Buffer for a Hash Engine

This block keeps one message block for a hash accelerator in a bank of word registers. Software fills the words through a simple register strobe bus. It then writes a start command, and the block hands the whole block to the hash engine as one wide vector together with a one-cycle start pulse. The engine itself is not part of the block. Only its start pulse, its data vector and its hash-valid output are seen here.

The message words are sensitive, so the block wipes them on its own and does not wait for a reset. Three events trigger a wipe. The first is the first cycle in which the engine reports a finished hash. The second is a change of the owner identifier input, which marks a new user of the accelerator. The third is any cycle with the tamper alarm raised. Either of two synchronous resets also clears everything: the global reset and a reset dedicated to this peripheral. A wipe clears the bank, the copy handed to the engine, the record of which words have been written, and the bus read register. This means no read can return words left from before the wipe. A sticky status bit records that a wipe occurred, and reading the status clears it.

The bus address map works as follows. Word indices 0 to N_WORDS-1 address the message words. Address N_WORDS is the command word. Address N_WORDS+1 is the status word. All other addresses read as zero and ignore writes. Reads have one cycle of latency.

Top module: `zmb_msg_buffer`

## Requirements
- R1: While `rst` or `periph_rst` is high at a clock edge, all message words, the written-word record, the wipe status bit, `eng_start`, `eng_block` and `bus_rdata` are cleared. A peripheral reset alone is sufficient, and it does not set the wipe status bit.
- R2: A bus write to word index k (0 to 15) stores `bus_wdata`. A read of index k returns the stored word on `bus_rdata` in the cycle after the read strobe.
- R3: Writing 1 in bit 0 of the command word (address 16) starts a hash, but only if all 16 words have been written since the last wipe or reset. `eng_start` is then high for exactly the next cycle. From that cycle on, `eng_block` carries word k in bits [32k+31:32k]. A start with an incomplete message produces no pulse.
- R4: The rising edge of `hash_valid` wipes every word and `eng_block`, once per rising edge. Holding `hash_valid` high afterwards causes no further wipe, so words written while it stays high are kept.
- R5: A change of `owner_id` from one cycle to the next wipes every word. An unchanged `owner_id` never wipes.
- R6: Every cycle with `tamper` high wipes every word.
- R7: When a wipe trigger and a word write fall in the same cycle, the wipe wins and the written value is dropped.
- R8: Status word (address 17): bit 0 is set by any wipe and cleared by a status read. If a wipe coincides with a status read, bit 0 stays set. Bit 1 is high when all 16 words have been written since the last wipe or reset.
- R9: A read in the same cycle as a wipe returns 0x00000000, and every wipe also zeroes the held `bus_rdata`.
- R10: After any wipe, every word reads 0x00000000, status bit 1 is low, and a start command is ignored until all 16 words are written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Global synchronous reset, active high |
| periph_rst | input | 1 | Reset for this peripheral only, synchronous, active high |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| owner_id | input | 8 | Identifier of the current user of the accelerator |
| tamper | input | 1 | Physical attack alarm |
| hash_valid | input | 1 | Hash engine reports a finished digest |
| eng_start | output | 1 | One-cycle start pulse to the hash engine |
| eng_block | output | 512 | Message block forwarded to the hash engine |

## Verification
The hardest cases to reach are the collisions. These are a wipe trigger landing in the same clock as a word write, as a word read, or as a status read, and a `hash_valid` level that stays high after its edge. The bench drives every input on the falling clock edge, so it can raise `tamper` in exactly the cycle that carries a write or read strobe. It then observes the outcome only through later bus reads. For the held `hash_valid` case, the bench writes a word and reads it back while the level is still high. This shows that the edge detector fired only once.

// File: rtl/zmb_pkg.sv
package zmb_pkg;

  // Kind of register selected by a bus address
  typedef enum logic [1:0] {
    SEL_WORD,
    SEL_CTRL,
    SEL_STAT,
    SEL_NONE
  } zmb_sel_e;

  // Bit positions inside the command and status words
  localparam int unsigned CTRL_START_BIT = 0;
  localparam int unsigned STAT_WIPED_BIT = 0;
  localparam int unsigned STAT_FULL_BIT  = 1;

endpackage

// File: rtl/zmb_trigger.sv
// Collects the wipe causes into one zeroize strobe that acts at the current edge.
module zmb_trigger #(
  parameter int OWNER_W = 8
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               hash_valid,
  input  logic               tamper,
  input  logic [OWNER_W-1:0] owner_id,
  output logic               zeroize
);

  logic               hv_q;
  logic [OWNER_W-1:0] own_q;
  logic               own_seen;
  logic               hv_rise;
  logic               owner_chg;

  always_ff @(posedge clk) begin
    if (clr) begin
      hv_q     <= 1'b0;
      own_q    <= '0;
      own_seen <= 1'b0;
    end else begin
      hv_q     <= hash_valid;
      own_q    <= owner_id;
      own_seen <= 1'b1;
    end
  end

  assign hv_rise   = hash_valid & ~hv_q;
  assign owner_chg = own_seen & (owner_id != own_q);
  assign zeroize   = hv_rise | owner_chg | tamper;

  // R4: a completion edge wipes once, never on two adjacent cycles
  p_rise_once_r4: assert property (@(posedge clk) disable iff (clr)
    hv_rise |=> !hv_rise);

  // R5: a steady owner never produces a change strobe
  p_owner_steady_r5: assert property (@(posedge clk) disable iff (clr)
    (own_seen && $stable(owner_id)) |-> !owner_chg);

  // R6: tamper always reaches the wipe strobe
  p_tamper_wipes_r6: assert property (@(posedge clk) disable iff (clr)
    tamper |-> zeroize);

endmodule

// File: rtl/zmb_bank.sv
// Message word registers: flip-flops, so that a single edge can clear all of them.
module zmb_bank #(
  parameter int N_WORDS = 16,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = $clog2(N_WORDS)
) (
  input  logic                        clk,
  input  logic                        clr,
  input  logic                        zeroize,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [DATA_W-1:0]           rd_word,
  output logic [N_WORDS*DATA_W-1:0]   words_flat,
  output logic                        full
);

  logic [DATA_W-1:0]  mem  [N_WORDS];
  logic [N_WORDS-1:0] seen;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (clr || zeroize) begin
        mem[g]  <= '0;
        seen[g] <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        mem[g]  <= wr_data;
        seen[g] <= 1'b1;
      end
    end
    assign words_flat[g*DATA_W +: DATA_W] = mem[g];
  end

  assign rd_word = mem[rd_idx];
  assign full    = &seen;

  // R2: an accepted write is visible in its word one cycle later
  p_write_lands_r2: assert property (@(posedge clk) disable iff (clr)
    (wr_en && !zeroize) |=> (mem[$past(wr_idx)] == $past(wr_data)));

  // R7: a write that collides with a wipe leaves nothing behind
  p_write_dropped_r7: assert property (@(posedge clk) disable iff (clr)
    (wr_en && zeroize) |=> (words_flat == '0));

  // R10: after a wipe the bank is empty and no longer complete
  p_wipe_empties_r10: assert property (@(posedge clk) disable iff (clr)
    zeroize |=> (words_flat == '0 && !full));

endmodule

// File: rtl/zmb_ctrl.sv
// Start handling, forwarded block copy and sticky wipe flag.
module zmb_ctrl #(
  parameter int N_WORDS = 16,
  parameter int DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      clr,
  input  logic                      zeroize,
  input  logic                      start_req,
  input  logic                      full,
  input  logic [N_WORDS*DATA_W-1:0] words_flat,
  input  logic                      stat_rd,
  output logic                      eng_start,
  output logic [N_WORDS*DATA_W-1:0] eng_block,
  output logic                      wiped
);

  logic go;
  assign go = start_req & full & ~zeroize;

  always_ff @(posedge clk) begin
    if (clr) begin
      eng_start <= 1'b0;
      eng_block <= '0;
      wiped     <= 1'b0;
    end else begin
      eng_start <= go;
      if (zeroize)  eng_block <= '0;
      else if (go)  eng_block <= words_flat;
      if (zeroize)      wiped <= 1'b1;
      else if (stat_rd) wiped <= 1'b0;
    end
  end

  // R3: the engine is started only from a complete message
  p_start_full_r3: assert property (@(posedge clk) disable iff (clr)
    (start_req && !full) |=> !eng_start);

  // R4: a wipe also scrubs the copy held for the engine and raises the flag
  p_block_scrub_r4: assert property (@(posedge clk) disable iff (clr)
    zeroize |=> (eng_block == '0 && wiped));

  // R8: reading the status clears the flag unless a wipe coincides
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (clr)
    (stat_rd && !zeroize) |=> !wiped);

endmodule

// File: rtl/zmb_msg_buffer.sv
module zmb_msg_buffer
  import zmb_pkg::*;
#(
  parameter int N_WORDS = 16,
  parameter int DATA_W  = 32,
  parameter int OWNER_W = 8,
  parameter int ADDR_W  = $clog2(N_WORDS + 2)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      periph_rst,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic [OWNER_W-1:0]        owner_id,
  input  logic                      tamper,
  input  logic                      hash_valid,
  output logic                      eng_start,
  output logic [N_WORDS*DATA_W-1:0] eng_block
);

  localparam int IDX_W = $clog2(N_WORDS);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(N_WORDS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(N_WORDS + 1);

  logic                      clr;
  logic                      zeroize;
  zmb_sel_e                  sel;
  logic                      wr_en;
  logic                      start_req;
  logic                      stat_rd;
  logic [DATA_W-1:0]         rd_word;
  logic [DATA_W-1:0]         stat_word;
  logic [N_WORDS*DATA_W-1:0] words_flat;
  logic                      full;
  logic                      wiped;

  assign clr = rst | periph_rst;

  always_comb begin
    if (bus_addr < A_CTRL)       sel = SEL_WORD;
    else if (bus_addr == A_CTRL) sel = SEL_CTRL;
    else if (bus_addr == A_STAT) sel = SEL_STAT;
    else                         sel = SEL_NONE;
  end

  assign wr_en     = bus_wr & (sel == SEL_WORD);
  assign start_req = bus_wr & (sel == SEL_CTRL) & bus_wdata[CTRL_START_BIT];
  assign stat_rd   = bus_rd & (sel == SEL_STAT);

  zmb_trigger #(.OWNER_W(OWNER_W)) u_trigger (
    .clk        (clk),
    .clr        (clr),
    .hash_valid (hash_valid),
    .tamper     (tamper),
    .owner_id   (owner_id),
    .zeroize    (zeroize)
  );

  zmb_bank #(.N_WORDS(N_WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
    .clk        (clk),
    .clr        (clr),
    .zeroize    (zeroize),
    .wr_en      (wr_en),
    .wr_idx     (bus_addr[IDX_W-1:0]),
    .wr_data    (bus_wdata),
    .rd_idx     (bus_addr[IDX_W-1:0]),
    .rd_word    (rd_word),
    .words_flat (words_flat),
    .full       (full)
  );

  zmb_ctrl #(.N_WORDS(N_WORDS), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .clr        (clr),
    .zeroize    (zeroize),
    .start_req  (start_req),
    .full       (full),
    .words_flat (words_flat),
    .stat_rd    (stat_rd),
    .eng_start  (eng_start),
    .eng_block  (eng_block),
    .wiped      (wiped)
  );

  always_comb begin
    stat_word                 = '0;
    stat_word[STAT_WIPED_BIT] = wiped;
    stat_word[STAT_FULL_BIT]  = full;
  end

  // Read register: scrubbed by every wipe so no old word lingers on the port
  always_ff @(posedge clk) begin
    if (clr || zeroize) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (sel)
        SEL_WORD: bus_rdata <= rd_word;
        SEL_STAT: bus_rdata <= stat_word;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  // R9: a wipe leaves the read port at zero
  p_rdata_scrub_r9: assert property (@(posedge clk) disable iff (clr)
    zeroize |=> (bus_rdata == '0));

  // R1: either reset empties every output register
  p_reset_clean_r1: assert property (@(posedge clk)
    clr |=> (bus_rdata == '0 && !eng_start && eng_block == '0));

endmodule

// File: tb/zmb_msg_buffer_tb.sv
module zmb_msg_buffer_tb;

  localparam int NW = 16;
  localparam int DW = 32;

  logic           clk = 1'b0;
  logic           rst, periph_rst, bus_wr, bus_rd, tamper, hash_valid;
  logic [4:0]     bus_addr;
  logic [DW-1:0]  bus_wdata;
  logic [DW-1:0]  bus_rdata;
  logic [7:0]     owner_id;
  logic           eng_start;
  logic [NW*DW-1:0] eng_block;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  zmb_msg_buffer u_dut (
    .clk(clk), .rst(rst), .periph_rst(periph_rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .owner_id(owner_id), .tamper(tamper), .hash_valid(hash_valid),
    .eng_start(eng_start), .eng_block(eng_block)
  );

  function automatic logic [31:0] pat(input int i);
    return 32'hC0DE_0000 ^ (32'(i) * 32'h0101_0101) ^ 32'h0000_5A01;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic fill_all();
    for (int i = 0; i < NW; i++) wr(5'(i), pat(i));
  endtask

  task automatic start_cmd(output logic s1, output logic s2);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 5'd16; bus_wdata = 32'h1;
    @(negedge clk); bus_wr = 1'b0; s1 = eng_start;
    @(negedge clk); s2 = eng_start;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(32'(eng_start), 0, "R1 eng_start after reset");
    check(32'(eng_block == '0), 1, "R1 eng_block after reset");
    rd(5'd3, d);  check(d, 0, "R1 word after reset");
    rd(5'd17, d); check(d, 0, "R1 status after reset");
  endtask

  task automatic t_start_partial();
    logic s1, s2;
    wr(5'd0, pat(0));
    start_cmd(s1, s2);
    check(32'({s1, s2}), 0, "R3 start with incomplete message");
  endtask

  task automatic t_write_read();
    logic [31:0] d;
    fill_all();
    rd(5'd0, d);  check(d, pat(0), "R2 readback word 0");
    rd(5'd7, d);  check(d, pat(7), "R2 readback word 7");
    rd(5'd15, d); check(d, pat(15), "R2 readback word 15");
    rd(5'd17, d); check(d, 32'h2, "R8 status full bit");
  endtask

  task automatic t_start();
    logic s1, s2;
    start_cmd(s1, s2);
    check(32'(s1), 1, "R3 start pulse");
    check(32'(s2), 0, "R3 start pulse one cycle");
    check(eng_block[0 +: 32], pat(0), "R3 block word 0");
    check(eng_block[15*32 +: 32], pat(15), "R3 block word 15");
  endtask

  task automatic t_hash_done();
    logic [31:0] d;
    logic s1, s2;
    @(negedge clk); hash_valid = 1'b1;
    @(negedge clk);
    check(32'(eng_block == '0), 1, "R4 block scrubbed on completion");
    rd(5'd4, d);  check(d, 0, "R4 word wiped on completion");
    rd(5'd17, d); check(d, 32'h1, "R10 status after wipe");
    rd(5'd17, d); check(d, 32'h0, "R8 flag cleared by read");
    wr(5'd5, pat(5));
    rd(5'd5, d);  check(d, pat(5), "R4 no repeat wipe while held");
    start_cmd(s1, s2);
    check(32'({s1, s2}), 0, "R10 start ignored after wipe");
    @(negedge clk); hash_valid = 1'b0;
  endtask

  task automatic t_owner();
    logic [31:0] d;
    wr(5'd2, 32'h1234_5678);
    rd(5'd17, d);
    @(negedge clk); owner_id = 8'h5A;
    @(negedge clk);
    rd(5'd2, d);  check(d, 0, "R5 owner change wipes");
    rd(5'd17, d); check(d, 32'h1, "R8 flag set by owner change");
    wr(5'd2, 32'h1234_5678);
    rd(5'd2, d);  check(d, 32'h1234_5678, "R5 steady owner keeps data");
  endtask

  task automatic t_tamper();
    logic [31:0] d;
    wr(5'd11, 32'hDEAD_BEEF);
    @(negedge clk); tamper = 1'b1;
    @(negedge clk); tamper = 1'b0;
    rd(5'd11, d); check(d, 0, "R6 tamper wipes");
  endtask

  task automatic t_collide();
    logic [31:0] d;
    @(negedge clk); bus_wr = 1'b1; bus_addr = 5'd7; bus_wdata = 32'hFACE_CAFE; tamper = 1'b1;
    @(negedge clk); bus_wr = 1'b0; tamper = 1'b0;
    rd(5'd7, d); check(d, 0, "R7 write dropped on wipe");
  endtask

  task automatic t_read_wipe();
    logic [31:0] d;
    wr(5'd9, 32'h0BAD_F00D);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 5'd9; tamper = 1'b1;
    @(negedge clk); bus_rd = 1'b0; tamper = 1'b0;
    check(bus_rdata, 0, "R9 read during wipe returns zero");
    rd(5'd17, d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 5'd17; tamper = 1'b1;
    @(negedge clk); bus_rd = 1'b0; tamper = 1'b0;
    rd(5'd17, d); check(d & 32'h1, 32'h1, "R8 flag kept when wipe meets status read");
  endtask

  task automatic t_periph_rst();
    logic [31:0] d;
    @(negedge clk); tamper = 1'b1;
    @(negedge clk); tamper = 1'b0;
    wr(5'd1, 32'h7777_1111);
    @(negedge clk); periph_rst = 1'b1;
    @(negedge clk); periph_rst = 1'b0;
    rd(5'd1, d);  check(d, 0, "R1 peripheral reset wipes");
    rd(5'd17, d); check(d, 0, "R1 peripheral reset clears flag");
  endtask

  initial begin
    rst = 1'b1; periph_rst = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; owner_id = 8'h11; tamper = 1'b0; hash_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_start_partial();
    t_write_read();
    t_start();
    t_hash_done();
    t_owner();
    t_tamper();
    t_collide();
    t_read_wipe();
    t_periph_rst();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule